// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is a single-master I2C controller. It drives an open-drain clock and data pair and runs whole write or read transfers from one command. The command carries a 7-bit target address, a direction, a byte count and a retry limit. Write bytes are taken from a data input, and each byte is acknowledged with a one-cycle take strobe. Read bytes come back on a data output with a one-cycle valid strobe.

Each bit time is split into four quarter-phases, and each quarter lasts `QTR` system clocks. SCL is low in the first and last quarters and released in the middle two. SDA changes only at the start of a bit, while SCL is low. The line is sampled at the end of the third quarter. When the target leaves the address unacknowledged, the sequencer issues a repeated START and sends the address again, up to the programmed limit. After the limit it closes with STOP and flags an address error. A read ends by leaving the last byte unacknowledged, then STOP. A NACK on any written byte ends the transfer with STOP and a data error.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, and whenever no transfer is running, both open-drain enables are low (lines released) and `busy_o` and `done_o` are low.
- R2: Each address attempt starts with a START: SDA falls while SCL is high.
- R3: The first byte after each START is the 7-bit address, MSB first, followed by the direction bit (1 = read, 0 = write).
- R4: Bit nine of every byte is the acknowledge slot, and SDA is sampled while SCL is high. A low level is ACK and a high level is NACK.
- R5: In a write, data bytes are sent in the order presented. The next byte is sent only after the previous one was ACKed. `wr_take_o` pulses once for each byte the block loads.
- R6: In a read, SDA is released for eight bits and each byte appears on `rd_data_o` with a one-cycle `rd_valid_o`. The block drives ACK after every byte except the last and leaves NACK after the last.
- R7: `busy_o` is high from the cycle after a command is accepted until STOP completes. Then `done_o` pulses for exactly one cycle, and the bus carries exactly one STOP per transfer.
- R8: An address NACK causes a repeated START and a new address attempt, up to `retry_lim_i` retries (at most `retry_lim_i`+1 STARTs). When the limit is used up, the transfer ends with STOP and `err_addr_o` is set, and no data bytes move.
- R9: A NACK on a written data byte ends the transfer with STOP and no further bytes, and sets `err_data_o`. The retry limit does not apply to it.
- R10: Apart from START and STOP, SDA never changes while SCL is high.
- R11: When nothing holds SCL low, consecutive SCL rising edges within a byte are 4*`QTR` system clocks apart.
- R12: While SCL is released but read low, the bit phase does not advance: SCL stays released and SDA holds.
- R13: A write with a byte count of 0 sends only the address, then STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request, accepted when idle |
| cmd_addr_i | input | 7 | Target address |
| cmd_rd_i | input | 1 | 1 = read, 0 = write |
| cmd_len_i | input | LEN_W | Number of data bytes |
| retry_lim_i | input | RETRY_W | Maximum address retries |
| wr_data_i | input | 8 | Next byte to write |
| wr_take_o | output | 1 | Pulse: write byte loaded |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Pulse: `rd_data_o` valid |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Pulse after STOP |
| err_addr_o | output | 1 | Address retries exhausted |
| err_data_o | output | 1 | Write byte was NACKed |
| scl_oe_o | output | 1 | Pull SCL low |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The hardest situation to reach is a long run of address NACKs that either ends just inside the retry limit or just exhausts it. Another is a written byte being refused partway through a burst. The bench contains a bus target model that counts STARTs and refuses a chosen number of address attempts and a chosen data byte index. It sweeps the retry limit against the number of refusals and moves the refused byte across the burst. Clock holding is reached by having the bench pull SCL low at a moment the block has released it.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} seq_st_e;
  typedef enum logic [1:0] {BK_ADDR, BK_WR, BK_RD} byte_kind_e;
endpackage

// File: rtl/i2c_qphase_gen.sv
module i2c_qphase_gen #(
  parameter int unsigned QTR = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       hold_i,
  output logic       tick_o,
  output logic [1:0] qtr_o
);
  localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(QTR - 1));
  assign tick_o = run_i && !hold_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      qtr_o <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      qtr_o <= '0;
    end else if (!hold_i) begin
      if (wrap) begin
        cnt_q <= '0;
        qtr_o <= qtr_o + 2'd1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R12: a held line freezes the quarter-phase
  a_r12_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i) |=> (!run_i || qtr_o == $past(qtr_o)));
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (load_i)  data_o <= load_val_i;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned QTR     = 4,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned RETRY_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic               cmd_rd_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [RETRY_W-1:0] retry_lim_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic               wr_take_o,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_addr_o,
  output logic               err_data_o,
  output logic               scl_oe_o,
  input  logic               scl_i,
  output logic               sda_oe_o,
  input  logic               sda_i
);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_W);
  localparam logic [3:0] LSB_BIT = 4'(BYTE_W - 1);

  seq_st_e            state_q;
  byte_kind_e         kind_q;
  logic [3:0]         bit_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [RETRY_W-1:0] lim_q, try_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               rd_q, samp_q;
  logic               done_q, take_q, rdv_q, err_a_q, err_d_q;
  logic [BYTE_W-1:0]  rd_data_q;

  logic               tick, hold, end_bit, samp_tick;
  logic [1:0]         qtr;
  logic               sh_load, sh_shift;
  logic [BYTE_W-1:0]  sh_val, sh_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign hold      = busy_o && !scl_oe_o && !scl_i;
  assign end_bit   = tick && (qtr == 2'd3);
  assign samp_tick = tick && (qtr == 2'd2);

  i2c_qphase_gen #(.QTR(QTR)) u_qphase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .hold_i (hold),
    .tick_o (tick),
    .qtr_o  (qtr)
  );

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (sh_val),
    .shift_i    (sh_shift),
    .bit_i      (samp_q),
    .data_o     (sh_q)
  );

  // shifter control mirrors the byte-end decisions below
  always_comb begin
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_val   = wr_data_i;
    if (state_q == ST_START && end_bit) begin
      sh_load = 1'b1;
      sh_val  = {addr_q, rd_q};
    end else if (state_q == ST_BYTE && end_bit) begin
      if (bit_q != ACK_BIT) sh_shift = 1'b1;
      else if (kind_q == BK_ADDR && !samp_q && !rd_q && cnt_q != '0) sh_load = 1'b1;
      else if (kind_q == BK_WR && !samp_q && cnt_q != LEN_W'(1)) sh_load = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= BK_ADDR;
      bit_q     <= '0;
      cnt_q     <= '0;
      lim_q     <= '0;
      try_q     <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      samp_q    <= 1'b1;
      done_q    <= 1'b0;
      take_q    <= 1'b0;
      rdv_q     <= 1'b0;
      err_a_q   <= 1'b0;
      err_d_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      take_q <= 1'b0;
      rdv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          addr_q  <= cmd_addr_i;
          rd_q    <= cmd_rd_i;
          cnt_q   <= cmd_len_i;
          lim_q   <= retry_lim_i;
          try_q   <= '0;
          err_a_q <= 1'b0;
          err_d_q <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: if (end_bit) begin
          state_q <= ST_BYTE;
          kind_q  <= BK_ADDR;
          bit_q   <= '0;
        end
        ST_BYTE: begin
          if (samp_tick) samp_q <= sda_i;
          if (end_bit) begin
            if (bit_q != ACK_BIT) begin
              bit_q <= bit_q + 4'd1;
              if (kind_q == BK_RD && bit_q == LSB_BIT) begin
                rdv_q     <= 1'b1;
                rd_data_q <= {sh_q[BYTE_W-2:0], samp_q};
              end
            end else begin
              bit_q <= '0;
              unique case (kind_q)
                BK_ADDR: begin
                  if (samp_q) begin
                    if (try_q < lim_q) begin
                      try_q   <= try_q + RETRY_W'(1);
                      state_q <= ST_START;
                    end else begin
                      err_a_q <= 1'b1;
                      state_q <= ST_STOP;
                    end
                  end else if (cnt_q == '0) begin
                    state_q <= ST_STOP;
                  end else if (rd_q) begin
                    kind_q <= BK_RD;
                  end else begin
                    kind_q <= BK_WR;
                    take_q <= 1'b1;
                  end
                end
                BK_WR: begin
                  if (samp_q) begin
                    err_d_q <= 1'b1;
                    state_q <= ST_STOP;
                  end else if (cnt_q == LEN_W'(1)) begin
                    state_q <= ST_STOP;
                  end else begin
                    cnt_q  <= cnt_q - LEN_W'(1);
                    take_q <= 1'b1;
                  end
                end
                default: begin
                  if (cnt_q == LEN_W'(1)) state_q <= ST_STOP;
                  else cnt_q <= cnt_q - LEN_W'(1);
                end
              endcase
            end
          end
        end
        default: if (end_bit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      endcase
    end
  end

  // line levels per quarter: bits low-high-high-low on SCL
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_START: begin
        scl_oe_o = (qtr == 2'd0) || (qtr == 2'd3);
        sda_oe_o = qtr[1];
      end
      ST_BYTE: begin
        scl_oe_o = (qtr == 2'd0) || (qtr == 2'd3);
        if (bit_q == ACK_BIT) sda_oe_o = (kind_q == BK_RD) && (cnt_q != LEN_W'(1));
        else                  sda_oe_o = (kind_q != BK_RD) && !sh_q[BYTE_W-1];
      end
      ST_STOP: begin
        scl_oe_o = (qtr == 2'd0);
        sda_oe_o = !qtr[1];
      end
      default: ;
    endcase
  end

  assign done_o     = done_q;
  assign wr_take_o  = take_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rd_data_q;
  assign err_addr_o = err_a_q;
  assign err_data_o = err_d_q;

  // R10: SDA moves under a high SCL only inside START or STOP
  a_r10_sda_under_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && sda_oe_o != $past(sda_oe_o))
      |-> ($past(state_q) == ST_START || $past(state_q) == ST_STOP));

  // R7: done follows the end of busy and never overlaps it
  a_r7_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_busy_ends_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R8: retry counter stays within the programmed limit
  a_r8_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (try_q <= lim_q));

  // R5: byte takes only in writes; R6: read strobes only in reads
  a_r5_take_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> (!rd_q && busy_o));
  a_r6_valid_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_q && busy_o));

  // R9: data error arises only in writes
  a_r9_data_err_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_data_o) |-> !rd_q);

  // R7: the strobes never coincide
  a_r7_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, wr_take_o, rd_valid_o}));
endmodule

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic       cmd_rd = 1'b0;
  logic [3:0] cmd_len = '0;
  logic [2:0] retry_lim = '0;
  logic [7:0] wr_data;
  logic       wr_take, rd_valid, busy, done, err_addr, err_data;
  logic [7:0] rd_data;
  logic       scl_oe, sda_oe, scl_i, sda_i;
  logic       stretch = 1'b0;
  logic       slv_low = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // transfer setup (written by stimulus only)
  logic [6:0] cur_addr = '0;
  int nack_addr_n = 0;
  int nack_data_at = 99;
  bit stretch_used = 1'b0;

  // target model state (written by monitor only)
  int starts = 0, stops = 0, bitcnt = 0, rx_n = 0, rd_n = 0, takes = 0;
  int macks = 0, mnacks = 0, widx = 0, tx_n = 0, last_rise = -1;
  int period_n = 0, period_bad = 0;
  bit active = 0, skip_fall = 0, is_addr = 0, reading = 0, xmit = 0, addr_ok = 0, mack = 0;
  bit p_scl = 1, p_sda = 1, p_busy = 0;
  logic [7:0] sh = '0, tx = '0, addr_seen = '0;
  logic [7:0] rx_got [16];
  logic [7:0] rd_got [16];

  function automatic logic [7:0] wpat(input logic [6:0] a, input int i);
    return 8'((int'(a) * 13 + i * 59 + 3) & 255);
  endfunction
  function automatic logic [7:0] tpat(input logic [6:0] a, input int i);
    return 8'((int'(a) * 29 + i * 71 + 129) & 255);
  endfunction

  assign wr_data = wpat(cur_addr, widx);
  assign scl_i   = !(scl_oe || stretch);
  assign sda_i   = !(sda_oe || slv_low);

  i2c_xfer_seq #(.QTR(QTR), .LEN_W(4), .RETRY_W(3)) u_i2c_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
    .cmd_rd_i(cmd_rd), .cmd_len_i(cmd_len), .retry_lim_i(retry_lim),
    .wr_data_i(wr_data), .wr_take_o(wr_take), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .busy_o(busy), .done_o(done), .err_addr_o(err_addr), .err_data_o(err_data),
    .scl_oe_o(scl_oe), .scl_i(scl_i), .sda_oe_o(sda_oe), .sda_i(sda_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bus target model and strobe capture, sampled away from the active edge
  always @(negedge clk) begin
    logic scl_v;
    scl_v = scl_i || stretch;
    if (busy && !p_busy) begin
      starts = 0; stops = 0; rx_n = 0; rd_n = 0; takes = 0; macks = 0; mnacks = 0;
      widx = 0; tx_n = 0; addr_seen = '0;
    end
    if (wr_take) begin takes++; widx++; end
    if (rd_valid) begin
      if (rd_n < 16) rd_got[rd_n] = rd_data;
      rd_n++;
    end
    if (p_scl && scl_v && p_sda && !sda_i) begin
      starts++; bitcnt = 0; skip_fall = 1; is_addr = 1; active = 1; xmit = 0;
      slv_low = 0; last_rise = -1;
    end else if (p_scl && scl_v && !p_sda && sda_i) begin
      stops++; active = 0; slv_low = 0;
    end else if (active && !p_scl && scl_v) begin
      if (bitcnt < 8) sh = {sh[6:0], sda_i};
      else if (reading && !is_addr) begin
        mack = !sda_i;
        if (mack) macks++; else mnacks++;
      end
      if (last_rise >= 0 && bitcnt >= 1 && bitcnt <= 8 && !stretch_used) begin
        period_n++;
        if (cyc - last_rise != 4 * QTR) period_bad++;
      end
      last_rise = cyc;
    end else if (active && p_scl && !scl_v) begin
      if (skip_fall) skip_fall = 0;
      else begin
        bitcnt++;
        if (bitcnt == 8) begin
          if (is_addr) begin
            addr_seen = sh; reading = sh[0];
            addr_ok = (starts > nack_addr_n);
            slv_low = addr_ok;
          end else if (!reading) begin
            if (rx_n < 16) rx_got[rx_n] = sh;
            slv_low = (rx_n != nack_data_at);
            rx_n++;
          end else slv_low = 0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (reading && ((is_addr && addr_ok) || (!is_addr && mack))) begin
            tx = tpat(cur_addr, tx_n); tx_n++; xmit = 1; slv_low = !tx[7];
          end else begin
            xmit = 0; slv_low = 0;
          end
          is_addr = 0;
        end else if (xmit) slv_low = !tx[7 - bitcnt];
      end
    end
    p_scl = scl_v; p_sda = sda_i; p_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] a, input bit rd, input int len, input int lim,
                     input int nn, input int nd, input bit do_stretch);
    int n;
    int tries;
    int nexp;
    bit ea;
    bit stable;
    logic s0;
    cur_addr = a; nack_addr_n = nn; nack_data_at = nd; stretch_used = do_stretch;
    @(negedge clk);
    cmd_addr = a; cmd_rd = rd; cmd_len = 4'(len); retry_lim = 3'(lim); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    if (do_stretch) begin
      repeat (150) @(negedge clk);
      while (scl_oe) @(negedge clk);
      stable = 1; s0 = sda_oe; stretch = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (scl_oe || sda_oe != s0) stable = 0;
      end
      stretch = 1'b0;
      chk(stable, "R12 phase frozen while SCL held", int'(stable), 1);
    end
    n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R7 done after transfer", int'(done), 1);
    tries = (nn < lim) ? nn + 1 : lim + 1;
    ea = (nn > lim);
    chk(starts == tries, "R8 R2 R10 START count", starts, tries);
    chk(stops == 1, "R7 R10 STOP count", stops, 1);
    chk(addr_seen == {a, rd}, "R3 address byte", int'(addr_seen), int'({a, rd}));
    chk(err_addr == ea, "R8 address error flag", int'(err_addr), int'(ea));
    if (ea) begin
      chk(rx_n + rd_n + takes == 0, "R8 no data after failed address", rx_n + rd_n + takes, 0);
    end else if (!rd) begin
      nexp = (nd < len) ? nd + 1 : len;
      chk(rx_n == nexp, "R5 R9 R13 bytes on bus", rx_n, nexp);
      chk(takes == nexp, "R5 take strobes", takes, nexp);
      chk(err_data == (nd < len), "R9 data error flag", int'(err_data), int'(nd < len));
      for (int i = 0; i < nexp && i < 16; i++)
        chk(rx_got[i] == wpat(a, i), "R5 R4 written byte", int'(rx_got[i]), int'(wpat(a, i)));
    end else begin
      chk(rd_n == len, "R6 read strobes", rd_n, len);
      chk(macks == len - 1, "R6 master ACKs", macks, len - 1);
      chk(mnacks == 1, "R6 final NACK", mnacks, 1);
      chk(err_data == 1'b0, "R9 no data error on read", int'(err_data), 0);
      for (int i = 0; i < len && i < 16; i++)
        chk(rd_got[i] == tpat(a, i), "R6 read byte", int'(rd_got[i]), int'(tpat(a, i)));
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    chk(!scl_oe && !sda_oe && !busy, "R1 lines released when idle",
        int'({scl_oe, sda_oe, busy}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state",
        int'({scl_oe, sda_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1 idle after reset", int'({scl_oe, sda_oe, busy}), 0);

    for (int len = 1; len <= 4; len++) run(7'(7'h21 + len * 9), 1'b0, len, 1, 0, 99, 1'b0);
    for (int len = 1; len <= 4; len++) run(7'(7'h50 + len * 5), 1'b1, len, 1, 0, 99, 1'b0);
    chk(period_n > 0 && period_bad == 0, "R11 bit period", period_bad, 0);
    for (int lim = 0; lim <= 2; lim++)
      for (int nn = 0; nn <= 3; nn++)
        run(7'(7'h10 + lim * 4 + nn), 1'(nn & 1), 2, lim, nn, 99, 1'b0);
    for (int nd = 0; nd <= 2; nd++) run(7'(7'h3C + nd), 1'b0, 3, 2, 1, nd, 1'b0);
    run(7'h7E, 1'b0, 0, 0, 0, 99, 1'b0);
    run(7'h01, 1'b0, 2, 0, 0, 99, 1'b1);
    run(7'h66, 1'b1, 1, 3, 3, 99, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule